// File: doc/BRIEF.md
# Serial Programming Slave Interface

This block sits inside a target chip and lets an external programmer read and write the on-chip program memory and data EEPROM over a three-wire serial link (clock, data in, data out). The link is live only while the chip's active-low reset pin is held low. The serial clock is treated as a slow asynchronous input: the block synchronizes it into the CPU clock domain, finds its edges by oversampling, and assembles 32-bit instruction frames most significant bit first.

Every instruction is four bytes long. The first byte selects the operation. The second and third bytes carry the address. The fourth byte carries write data, or the read data on the return line. The block issues single-cycle read, write and erase strobes to synchronous memory models outside the top module. No memory operation is honoured until an enable instruction has been accepted in the current reset-low session. A fixed busy window follows each write or erase.

Top module: `isp_serial_slave`

## Requirements
- R1: The link is active only while `prog_rst_n` is low. While it is high, every strobe and `miso_out` stay 0. Raising it discards any partially received frame and clears the enable state, so the next frame after it goes low again starts at its first bit.
- R2: Until a frame of `0xAC 0x53 xx xx` has been received in the current low period of `prog_rst_n`, read, write and erase frames raise no strobe, and read frames return 0x00 in the fourth byte.
- R3: Frames are exactly 32 serial clocks long, most significant bit first. Byte 1 is the opcode, bytes 2 and 3 are the address, and byte 4 is the data.
- R4: `mosi_in` is taken at rising edges of `sck_in`. `miso_out` changes only in the clock after a falling edge of `sck_in` is detected. Edge detection uses a two-flop synchronizer and needs both SCK phases to last more than 2 CPU clocks.
- R5: In a frame whose first two bytes are `0xAC 0x53`, the block returns 0x53 during byte 3. In every other byte position that is not read data, it returns 0x00.
- R6: Opcode 0x20 reads the low byte and 0x28 reads the high byte of a program word. The 14-bit word address is `{byte2[5:0], byte3}`, and `pm_hi` equals opcode bit 3. The data returned on `pm_rdata` is shifted out during byte 4.
- R7: Opcode 0xA0 reads the EEPROM at the 10-bit byte address `{byte2[1:0], byte3}`. The data returned on `ee_rdata` is shifted out during byte 4.
- R8: Opcode 0x40 (low) or 0x48 (high) raises one `pm_wr` pulse with byte 4 on `wdata` and no erase strobe. Opcode 0xC0 raises `ee_erase` for one clock and then `ee_wr` for one clock at the same address, so the byte is replaced without a prior chip erase.
- R9: The frame `0xAC 0x80 xx xx` raises a single one-clock `chip_erase` pulse. The memories set every location of both arrays to 0xFF on it. At most one strobe is high in any clock.
- R10: Each accepted write or erase starts a busy window of `BUSY_CYCLES` clocks. Write and erase frames that end inside the window are ignored. Read frames are still served.
- R11: Frames with any other opcode raise no strobe and return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| prog_rst_n | input | 1 | Active-low reset pin; low selects serial programming mode and high clears all state |
| sck_in | input | 1 | Serial clock from the programmer |
| mosi_in | input | 1 | Serial data from the programmer |
| miso_out | output | 1 | Serial data to the programmer |
| pm_addr | output | PM_AW | Program memory word address |
| pm_hi | output | 1 | Program memory byte select (1 = high byte) |
| pm_rd | output | 1 | Program memory read strobe |
| pm_wr | output | 1 | Program memory write strobe |
| pm_rdata | input | 8 | Program memory read data, valid the clock after `pm_rd` |
| ee_addr | output | EE_AW | EEPROM byte address |
| ee_rd | output | 1 | EEPROM read strobe |
| ee_erase | output | 1 | EEPROM byte erase strobe |
| ee_wr | output | 1 | EEPROM write strobe |
| ee_rdata | input | 8 | EEPROM read data, valid the clock after `ee_rd` |
| wdata | output | 8 | Write data for either memory |
| chip_erase | output | 1 | Whole-array erase strobe |

## Verification
The assertions check, on every clock, the properties that hold whatever the frame contents are. While the link is inactive the outputs are quiet. No strobe is raised before enable. The return line moves only after a detected falling SCK edge. The EEPROM erase and write pulses always come as an ordered pair. No write starts while busy, and at most one strobe is high at a time. The bench scenarios are the only way to show the values that depend on frame contents: the echo byte, the address bit slicing, the returned read data, the overwrite result of an EEPROM write compared with the AND result of a program write, the frame realignment after reset is toggled mid-frame, and which frames fall inside the busy window.

// File: rtl/isp_pkg.sv
package isp_pkg;

  localparam int FRAME_BYTES = 4;
  localparam int FRAME_BITS  = FRAME_BYTES * 8;

  localparam logic [7:0] OPC_GROUP   = 8'hAC;
  localparam logic [7:0] SUB_ENABLE  = 8'h53;
  localparam logic [7:0] SUB_ERASE   = 8'h80;
  localparam logic [7:0] OPC_PM_RD_L = 8'h20;
  localparam logic [7:0] OPC_PM_RD_H = 8'h28;
  localparam logic [7:0] OPC_PM_WR_L = 8'h40;
  localparam logic [7:0] OPC_PM_WR_H = 8'h48;
  localparam logic [7:0] OPC_EE_RD   = 8'hA0;
  localparam logic [7:0] OPC_EE_WR   = 8'hC0;
  localparam logic [7:0] ECHO_VALUE  = 8'h53;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_ENABLE,
    OP_ERASE,
    OP_PM_RD,
    OP_PM_WR,
    OP_EE_RD,
    OP_EE_WR
  } isp_op_e;

  function automatic isp_op_e decode_op(input logic [7:0] b1, input logic [7:0] b2);
    isp_op_e op;
    op = OP_NONE;
    if (b1 == OPC_GROUP && b2 == SUB_ENABLE)                op = OP_ENABLE;
    else if (b1 == OPC_GROUP && b2 == SUB_ERASE)            op = OP_ERASE;
    else if (b1 == OPC_PM_RD_L || b1 == OPC_PM_RD_H)        op = OP_PM_RD;
    else if (b1 == OPC_PM_WR_L || b1 == OPC_PM_WR_H)        op = OP_PM_WR;
    else if (b1 == OPC_EE_RD)                               op = OP_EE_RD;
    else if (b1 == OPC_EE_WR)                               op = OP_EE_WR;
    return op;
  endfunction

  function automatic logic [15:0] join_addr(input logic [7:0] b2, input logic [7:0] b3);
    return {b2, b3};
  endfunction

  function automatic logic is_write_op(input isp_op_e op);
    return (op == OP_PM_WR) || (op == OP_EE_WR) || (op == OP_ERASE);
  endfunction

endpackage

// File: rtl/isp_sck_sync.sv
module isp_sck_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic clr,
  input  logic sck_in,
  input  logic mosi_in,
  output logic sck_rise,
  output logic sck_fall,
  output logic mosi_bit
);

  logic [SYNC_STAGES-1:0] sck_pipe;
  logic [SYNC_STAGES-1:0] mosi_pipe;
  logic                   sck_last;
  logic                   sck_s;

  always_ff @(posedge clk) begin
    if (clr) begin
      sck_pipe  <= '0;
      mosi_pipe <= '0;
      sck_last  <= 1'b0;
    end else begin
      sck_pipe  <= {sck_pipe[SYNC_STAGES-2:0], sck_in};
      mosi_pipe <= {mosi_pipe[SYNC_STAGES-2:0], mosi_in};
      sck_last  <= sck_s;
    end
  end

  assign sck_s    = sck_pipe[SYNC_STAGES-1];
  assign mosi_bit = mosi_pipe[SYNC_STAGES-1];
  assign sck_rise = sck_s & ~sck_last;
  assign sck_fall = ~sck_s & sck_last;

endmodule

// File: rtl/isp_frame_rx.sv
module isp_frame_rx
  import isp_pkg::*;
(
  input  logic                        clk,
  input  logic                        clr,
  input  logic                        sck_rise,
  input  logic                        mosi_bit,
  output logic                        byte_done,
  output logic [$clog2(FRAME_BYTES)-1:0] byte_idx,
  output logic [FRAME_BITS-1:0]       frame_now
);

  localparam int CW = $clog2(FRAME_BITS);

  logic [CW-1:0]         bit_cnt;
  logic [FRAME_BITS-1:0] shift_q;

  always_ff @(posedge clk) begin
    if (clr) begin
      bit_cnt <= '0;
      shift_q <= '0;
    end else if (sck_rise) begin
      bit_cnt <= bit_cnt + CW'(1);
      shift_q <= frame_now;
    end
  end

  assign frame_now = {shift_q[FRAME_BITS-2:0], mosi_bit};
  assign byte_done = sck_rise && (bit_cnt[2:0] == 3'b111);
  assign byte_idx  = bit_cnt[CW-1:3];

endmodule

// File: rtl/isp_miso_tx.sv
module isp_miso_tx (
  input  logic       clk,
  input  logic       clr,
  input  logic       load,
  input  logic [7:0] load_val,
  input  logic       sck_fall,
  output logic       miso
);

  logic [7:0] tx_q;

  always_ff @(posedge clk) begin
    if (clr) begin
      tx_q <= '0;
      miso <= 1'b0;
    end else if (load) begin
      tx_q <= load_val;
    end else if (sck_fall) begin
      miso <= tx_q[7];
      tx_q <= {tx_q[6:0], 1'b0};
    end
  end

endmodule

// File: rtl/isp_busy_timer.sv
module isp_busy_timer #(
  parameter int CYCLES = 700
) (
  input  logic clk,
  input  logic clr,
  input  logic start,
  output logic busy
);

  localparam int CW = $clog2(CYCLES + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (clr)             cnt <= '0;
    else if (start)      cnt <= CW'(CYCLES);
    else if (cnt != '0)  cnt <= cnt - CW'(1);
  end

  assign busy = (cnt != '0);

endmodule

// File: rtl/isp_serial_slave.sv
module isp_serial_slave
  import isp_pkg::*;
#(
  parameter int PM_AW       = 14,
  parameter int EE_AW       = 10,
  parameter int BUSY_CYCLES = 700,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             prog_rst_n,
  input  logic             sck_in,
  input  logic             mosi_in,
  output logic             miso_out,
  output logic [PM_AW-1:0] pm_addr,
  output logic             pm_hi,
  output logic             pm_rd,
  output logic             pm_wr,
  input  logic [7:0]       pm_rdata,
  output logic [EE_AW-1:0] ee_addr,
  output logic             ee_rd,
  output logic             ee_erase,
  output logic             ee_wr,
  input  logic [7:0]       ee_rdata,
  output logic [7:0]       wdata,
  output logic             chip_erase
);

  localparam int IW = $clog2(FRAME_BYTES);

  // Named internal events (observed by the bound checker)
  logic                  clr;
  logic                  sck_rise;
  logic                  sck_fall;
  logic                  mosi_bit;
  logic                  byte_done;
  logic [IW-1:0]         byte_idx;
  logic [FRAME_BITS-1:0] fb;
  logic                  hdr_evt;
  logic                  addr_evt;
  logic                  frame_evt;
  logic                  enabled_q;
  logic                  busy;
  logic                  busy_start;
  isp_op_e               op_hdr;
  isp_op_e               op_addr;
  isp_op_e               op_frame;
  logic [15:0]           addr_mid;
  logic [15:0]           addr_end;
  logic                  rd_pend_q;
  logic                  rd_src_ee_q;
  logic                  tx_load;
  logic [7:0]            tx_val;
  logic                  accept_wr;

  assign clr = prog_rst_n;

  isp_sck_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .clr      (clr),
    .sck_in   (sck_in),
    .mosi_in  (mosi_in),
    .sck_rise (sck_rise),
    .sck_fall (sck_fall),
    .mosi_bit (mosi_bit)
  );

  isp_frame_rx u_rx (
    .clk       (clk),
    .clr       (clr),
    .sck_rise  (sck_rise),
    .mosi_bit  (mosi_bit),
    .byte_done (byte_done),
    .byte_idx  (byte_idx),
    .frame_now (fb)
  );

  // Byte-boundary events within a frame
  assign hdr_evt   = byte_done && (byte_idx == IW'(1));
  assign addr_evt  = byte_done && (byte_idx == IW'(2));
  assign frame_evt = byte_done && (byte_idx == IW'(FRAME_BYTES - 1));

  // Opcode view at each boundary (bytes sit in the low bits of fb)
  assign op_hdr   = decode_op(fb[15:8],  fb[7:0]);
  assign op_addr  = decode_op(fb[23:16], fb[15:8]);
  assign op_frame = decode_op(fb[31:24], fb[23:16]);
  assign addr_mid = join_addr(fb[15:8],  fb[7:0]);
  assign addr_end = join_addr(fb[23:16], fb[15:8]);

  assign accept_wr  = frame_evt && enabled_q && !busy && is_write_op(op_frame);
  assign busy_start = accept_wr;

  isp_busy_timer #(.CYCLES(BUSY_CYCLES)) u_busy (
    .clk   (clk),
    .clr   (clr),
    .start (busy_start),
    .busy  (busy)
  );

  // Enable handshake
  always_ff @(posedge clk) begin
    if (clr)                                    enabled_q <= 1'b0;
    else if (frame_evt && op_frame == OP_ENABLE) enabled_q <= 1'b1;
  end

  // Memory strobes and address/data registers
  always_ff @(posedge clk) begin
    if (clr) begin
      pm_rd       <= 1'b0;
      pm_wr       <= 1'b0;
      ee_rd       <= 1'b0;
      ee_erase    <= 1'b0;
      ee_wr       <= 1'b0;
      chip_erase  <= 1'b0;
      pm_addr     <= '0;
      pm_hi       <= 1'b0;
      ee_addr     <= '0;
      wdata       <= '0;
      rd_pend_q   <= 1'b0;
      rd_src_ee_q <= 1'b0;
    end else begin
      pm_rd       <= addr_evt && enabled_q && op_addr == OP_PM_RD;
      ee_rd       <= addr_evt && enabled_q && op_addr == OP_EE_RD;
      pm_wr       <= accept_wr && op_frame == OP_PM_WR;
      ee_erase    <= accept_wr && op_frame == OP_EE_WR;
      chip_erase  <= accept_wr && op_frame == OP_ERASE;
      ee_wr       <= ee_erase;
      rd_pend_q   <= pm_rd || ee_rd;
      rd_src_ee_q <= ee_rd;
      if (addr_evt && enabled_q) begin
        if (op_addr == OP_PM_RD) begin
          pm_addr <= addr_mid[PM_AW-1:0];
          pm_hi   <= fb[19];
        end
        if (op_addr == OP_EE_RD) ee_addr <= addr_mid[EE_AW-1:0];
      end
      if (accept_wr) begin
        wdata <= fb[7:0];
        if (op_frame == OP_PM_WR) begin
          pm_addr <= addr_end[PM_AW-1:0];
          pm_hi   <= fb[27];
        end
        if (op_frame == OP_EE_WR) ee_addr <= addr_end[EE_AW-1:0];
      end
    end
  end

  // Return byte selection: echo, read data or zero
  always_comb begin
    tx_load = byte_done || rd_pend_q;
    tx_val  = 8'h00;
    if (rd_pend_q)                       tx_val = rd_src_ee_q ? ee_rdata : pm_rdata;
    else if (hdr_evt && op_hdr == OP_ENABLE) tx_val = ECHO_VALUE;
  end

  isp_miso_tx u_tx (
    .clk      (clk),
    .clr      (clr),
    .load     (tx_load),
    .load_val (tx_val),
    .sck_fall (sck_fall),
    .miso     (miso_out)
  );

endmodule

// File: rtl/isp_serial_checker.sv
module isp_serial_checker (
  input logic clk,
  input logic prog_rst_n,
  input logic sck_fall,
  input logic miso_out,
  input logic enabled,
  input logic busy,
  input logic pm_rd,
  input logic pm_wr,
  input logic ee_rd,
  input logic ee_erase,
  input logic ee_wr,
  input logic chip_erase
);

  logic any_strobe;
  logic any_write;
  assign any_strobe = pm_rd | pm_wr | ee_rd | ee_erase | ee_wr | chip_erase;
  assign any_write  = pm_wr | ee_erase | chip_erase;

  AST_QUIET_OUT_OF_MODE: assert property (@(posedge clk)
    prog_rst_n |=> (!any_strobe && !miso_out));                              // R1

  AST_STROBE_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (prog_rst_n)
    any_strobe |-> enabled);                                                  // R2

  AST_ENABLE_HOLDS: assert property (@(posedge clk) disable iff (prog_rst_n)
    enabled |=> enabled);                                                     // R2

  AST_MISO_AFTER_FALL: assert property (@(posedge clk) disable iff (prog_rst_n)
    !$stable(miso_out) |-> $past(sck_fall));                                  // R4

  AST_EE_ERASE_THEN_WRITE: assert property (@(posedge clk) disable iff (prog_rst_n)
    ee_erase |=> ee_wr);                                                      // R8

  AST_EE_WRITE_AFTER_ERASE: assert property (@(posedge clk) disable iff (prog_rst_n)
    ee_wr |-> $past(ee_erase));                                               // R8

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (prog_rst_n)
    $onehot0({pm_rd, pm_wr, ee_rd, ee_erase, ee_wr, chip_erase}));            // R9

  AST_ERASE_SINGLE_PULSE: assert property (@(posedge clk) disable iff (prog_rst_n)
    chip_erase |=> !chip_erase);                                              // R9

  AST_WRITE_NOT_BUSY: assert property (@(posedge clk) disable iff (prog_rst_n)
    any_write |-> $past(!busy));                                              // R10

  AST_WRITE_STARTS_BUSY: assert property (@(posedge clk) disable iff (prog_rst_n)
    any_write |-> busy);                                                      // R10

endmodule

bind isp_serial_slave isp_serial_checker u_chk (
  .clk        (clk),
  .prog_rst_n (prog_rst_n),
  .sck_fall   (sck_fall),
  .miso_out   (miso_out),
  .enabled    (enabled_q),
  .busy       (busy),
  .pm_rd      (pm_rd),
  .pm_wr      (pm_wr),
  .ee_rd      (ee_rd),
  .ee_erase   (ee_erase),
  .ee_wr      (ee_wr),
  .chip_erase (chip_erase)
);

// File: tb/isp_serial_slave_bench.sv
module isp_serial_slave_bench;

  localparam int PM_AW = 14;
  localparam int EE_AW = 10;
  localparam int BUSY  = 700;
  localparam int HALF  = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic             prog_rst_n = 1'b1;
  logic             sck = 1'b0;
  logic             mosi = 1'b0;
  logic             miso;
  logic [PM_AW-1:0] pm_addr;
  logic             pm_hi, pm_rd, pm_wr;
  logic [7:0]       pm_rdata = 8'h00;
  logic [EE_AW-1:0] ee_addr;
  logic             ee_rd, ee_erase, ee_wr;
  logic [7:0]       ee_rdata = 8'h00;
  logic [7:0]       wdata;
  logic             chip_erase;

  isp_serial_slave #(.PM_AW(PM_AW), .EE_AW(EE_AW), .BUSY_CYCLES(BUSY)) u_isp_serial_slave (
    .clk(clk), .prog_rst_n(prog_rst_n), .sck_in(sck), .mosi_in(mosi), .miso_out(miso),
    .pm_addr(pm_addr), .pm_hi(pm_hi), .pm_rd(pm_rd), .pm_wr(pm_wr), .pm_rdata(pm_rdata),
    .ee_addr(ee_addr), .ee_rd(ee_rd), .ee_erase(ee_erase), .ee_wr(ee_wr), .ee_rdata(ee_rdata),
    .wdata(wdata), .chip_erase(chip_erase)
  );

  // Memory models: small aliased arrays, program write ANDs, erase sets 0xFF
  logic [7:0] pm_mem [128];
  logic [7:0] ee_mem [64];

  function automatic int pidx(input logic [PM_AW-1:0] a, input logic hi);
    return int'({a[5:0], hi});
  endfunction

  initial begin
    for (int i = 0; i < 128; i++) pm_mem[i] = 8'(i * 7 + 1);
    for (int i = 0; i < 64; i++)  ee_mem[i] = 8'(i) ^ 8'h5A;
  end

  always @(posedge clk) begin
    if (chip_erase) begin
      for (int i = 0; i < 128; i++) pm_mem[i] = 8'hFF;
      for (int i = 0; i < 64; i++)  ee_mem[i] = 8'hFF;
    end
    if (pm_wr)    pm_mem[pidx(pm_addr, pm_hi)] = pm_mem[pidx(pm_addr, pm_hi)] & wdata;
    if (pm_rd)    pm_rdata <= pm_mem[pidx(pm_addr, pm_hi)];
    if (ee_erase) ee_mem[ee_addr[5:0]] = 8'hFF;
    if (ee_wr)    ee_mem[ee_addr[5:0]] = ee_mem[ee_addr[5:0]] & wdata;
    if (ee_rd)    ee_rdata <= ee_mem[ee_addr[5:0]];
  end

  // Port monitor, sampled on the inactive edge
  int n_pm_rd = 0, n_pm_wr = 0, n_ee_rd = 0, n_ee_er = 0, n_ee_wr = 0, n_chip = 0;
  int n_order_err = 0, n_miso_hi = 0, n_quiet_err = 0;
  logic [PM_AW-1:0] last_pm_addr = '0;
  logic             last_pm_hi = 1'b0;
  logic [EE_AW-1:0] last_ee_addr = '0;
  logic             prev_ee_er = 1'b0;
  logic             prev_miso = 1'b0;

  always @(negedge clk) begin
    if (pm_rd) begin n_pm_rd++; last_pm_addr = pm_addr; last_pm_hi = pm_hi; end
    if (pm_wr) n_pm_wr++;
    if (ee_rd) begin n_ee_rd++; last_ee_addr = ee_addr; end
    if (ee_erase) n_ee_er++;
    if (ee_wr) begin n_ee_wr++; if (!prev_ee_er) n_order_err++; end
    if (chip_erase) n_chip++;
    if (miso !== prev_miso && sck) n_miso_hi++;
    if (prog_rst_n && (pm_rd | pm_wr | ee_rd | ee_erase | ee_wr | chip_erase | miso)) n_quiet_err++;
    prev_ee_er = ee_erase;
    prev_miso  = miso;
  end

  int checks = 0;
  int fails  = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [31:0] tx, input int nbits, output logic [31:0] rx);
    rx = '0;
    for (int i = 31; i > 31 - nbits; i--) begin
      mosi = tx[i];
      repeat (HALF) @(negedge clk);
      rx[i] = miso;
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      sck = 1'b0;
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic frame(input logic [31:0] tx, output logic [31:0] rx);
    xfer(tx, 32, rx);
  endtask

  task automatic enter_mode();
    @(negedge clk); prog_rst_n = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic leave_mode();
    @(negedge clk); prog_rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic wait_idle();
    repeat (BUSY + 100) @(negedge clk);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    repeat (6) @(negedge clk);
    chk("R1 miso idle while pin high", 32'(miso), 32'h0);
    chk("R1 no strobes while pin high", 32'(n_pm_rd + n_pm_wr + n_ee_rd + n_ee_er + n_chip), 32'h0);
  endtask

  task automatic t_pre_enable();
    logic [31:0] rx;
    frame(32'hC0_00_05_AA, rx);
    frame(32'hA0_00_05_00, rx);
    chk("R2 read before enable returns zero", rx, 32'h0);
    chk("R2 no strobes before enable", 32'(n_ee_rd + n_ee_er + n_ee_wr), 32'h0);
  endtask

  task automatic t_enable();
    logic [31:0] rx;
    frame(32'hAC_53_00_00, rx);
    chk("R5 R3 enable echo in byte 3", rx, 32'h0000_5300);
  endtask

  task automatic t_pm_read();
    logic [31:0] rx;
    frame(32'h20_3F_12_00, rx);
    chk("R6 low byte word address", 32'(last_pm_addr), 32'h3F12);
    chk("R6 low byte select", 32'(last_pm_hi), 32'h0);
    chk("R6 low byte data", rx, {24'h0, pm_mem[pidx(14'h3F12, 1'b0)]});
    frame(32'h28_FF_12_00, rx);
    chk("R6 R3 high byte address masked", 32'(last_pm_addr), 32'h3F12);
    chk("R6 high byte select", 32'(last_pm_hi), 32'h1);
    chk("R6 high byte data", rx, {24'h0, pm_mem[pidx(14'h3F12, 1'b1)]});
  endtask

  task automatic t_ee_read();
    logic [31:0] rx;
    frame(32'hA0_FF_07_00, rx);
    chk("R7 eeprom address", 32'(last_ee_addr), 32'h307);
    chk("R7 eeprom data", rx, {24'h0, ee_mem[7]});
    frame(32'hA0_00_05_00, rx);
    chk("R2 eeprom untouched before enable", rx, 32'h5F);
  endtask

  task automatic t_ee_write();
    logic [31:0] rx;
    int er0 = n_ee_er, wr0 = n_ee_wr;
    frame(32'hC0_00_09_3C, rx);
    chk("R8 one erase strobe", 32'(n_ee_er - er0), 32'h1);
    chk("R8 one write strobe", 32'(n_ee_wr - wr0), 32'h1);
    chk("R8 write follows erase", 32'(n_order_err), 32'h0);
    wait_idle();
    frame(32'hA0_00_09_00, rx);
    chk("R8 eeprom byte replaced", rx, 32'h3C);
  endtask

  task automatic t_pm_write();
    logic [31:0] rx;
    logic [7:0]  orig;
    int er0, ch0, wr0;
    frame(32'h20_00_02_00, rx);
    orig = rx[7:0];
    er0 = n_ee_er; ch0 = n_chip; wr0 = n_pm_wr;
    frame(32'h40_00_02_0F, rx);
    chk("R8 program write strobe", 32'(n_pm_wr - wr0), 32'h1);
    chk("R8 program write has no erase", 32'(n_ee_er - er0 + n_chip - ch0), 32'h0);
    wait_idle();
    frame(32'h20_00_02_00, rx);
    chk("R8 program byte not pre-erased", rx, {24'h0, orig & 8'h0F});
  endtask

  task automatic t_busy();
    logic [31:0] rx;
    int wr0;
    frame(32'hC0_00_0B_66, rx);
    frame(32'hA0_00_0B_00, rx);
    chk("R10 read served while busy", rx, 32'h66);
    wait_idle();
    wr0 = n_ee_wr;
    frame(32'hC0_00_0D_44, rx);
    frame(32'hC0_00_0C_77, rx);
    chk("R10 write inside busy window ignored", 32'(n_ee_wr - wr0), 32'h1);
    wait_idle();
    frame(32'hA0_00_0C_00, rx);
    chk("R10 ignored write left data", rx, 32'(8'h0C ^ 8'h5A));
  endtask

  task automatic t_unknown();
    logic [31:0] rx;
    int tot0 = n_pm_rd + n_pm_wr + n_ee_rd + n_ee_er + n_ee_wr + n_chip;
    frame(32'h55_AC_53_00, rx);
    chk("R11 unknown opcode returns zero", rx, 32'h0);
    chk("R11 unknown opcode no strobe",
        32'(n_pm_rd + n_pm_wr + n_ee_rd + n_ee_er + n_ee_wr + n_chip - tot0), 32'h0);
  endtask

  task automatic t_chip_erase();
    logic [31:0] rx;
    int ch0 = n_chip;
    frame(32'hAC_80_00_00, rx);
    chk("R9 single erase pulse", 32'(n_chip - ch0), 32'h1);
    wait_idle();
    frame(32'h20_00_03_00, rx);
    chk("R9 program array erased", rx, 32'hFF);
    frame(32'hA0_00_21_00, rx);
    chk("R9 eeprom array erased", rx, 32'hFF);
  endtask

  task automatic t_abort();
    logic [31:0] rx;
    int rd0;
    xfer(32'hAC_53_00_00, 16, rx);
    leave_mode();
    enter_mode();
    rd0 = n_ee_rd;
    frame(32'hA0_00_05_00, rx);
    chk("R1 enable cleared by pin release", rx, 32'h0);
    chk("R1 no read strobe after release", 32'(n_ee_rd - rd0), 32'h0);
    frame(32'hAC_53_00_00, rx);
    chk("R1 frame realigned after release", rx, 32'h0000_5300);
  endtask

  task automatic t_edges();
    chk("R4 miso never changes while sck high", 32'(n_miso_hi), 32'h0);
    leave_mode();
    chk("R1 quiet outputs while pin high", 32'(n_quiet_err), 32'h0);
  endtask

  bit done = 1'b0;

  initial begin
    t_reset();
    enter_mode();
    t_pre_enable();
    t_enable();
    t_pm_read();
    t_ee_read();
    t_ee_write();
    t_pm_write();
    t_busy();
    t_unknown();
    t_chip_erase();
    t_abort();
    t_edges();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule